// File: doc/BRIEF.md
# Four-Phase Nested Clock Sequencer

This block derives the four timing strobes of a slow, phase-driven processor from one fast reference clock. A full instruction cycle is split into four equal phases of `PHASE_TICKS` reference ticks. Phases one and three each drive a pair of strobes: an activate strobe and a clear strobe. Phases two and four drive nothing and serve only as settling time. Each clear strobe sits strictly inside its activate strobe. Clearing and setting a storage element therefore overlap rather than follow one another.

A small control front end lets software or a front panel run the machine continuously or advance it one cycle at a time. A run pulse starts back-to-back cycles. A stop request is honoured only at a cycle boundary. A rising edge on the step input runs exactly one cycle. The same block contains a demonstration datapath driven by the strobes. In phase one, working register D takes the adder output, which is adder input latch A plus an increment operand. In phase three, latch A takes the value of register D. Repeated cycles therefore make register D count up by the increment.

Top module: `phase_clock_seq`

## Requirements
- R1: While reset is asserted and after it is released, all four strobes and `busy` are low, and `regD` and `latchA` are zero.
- R2: Counting reference ticks from the first tick of a cycle as 0 to 4·P−1, where P is `PHASE_TICKS`, `ph1Act` is high on ticks 0 to P−1 and `ph3Act` is high on ticks 2P to 3P−1. No strobe is high during ticks P to 2P−1 or 3P to 4P−1.
- R3: Each clear strobe is high from the second tick to the next-to-last tick of its phase, so it rises one tick after its activate strobe and falls one tick before it. A clear strobe is never high while its activate strobe is low.
- R4: On the last tick of the phase-one activate, `regD` loads `latchA + incValue`, truncated to `DATA_W` bits. On the last tick of the phase-three activate, `latchA` loads `regD`. After n cycles from reset, both hold n·incValue modulo 2^DATA_W.
- R5: A rising edge on `stepReq` while idle starts one cycle on the next tick. The block then returns to idle, with `busy` low, after 4·P ticks.
- R6: Holding `stepReq` high produces only one cycle.
- R7: A rising edge on `stepReq` while a cycle is in progress is ignored: it neither extends nor repeats the cycle.
- R8: A one-tick `runReq` pulse starts cycles that follow each other with no idle tick in between.
- R9: A `stopReq` pulse ends running only at the end of the current cycle. A stop sampled on the last tick of a cycle prevents the next cycle. A stop sampled on the first tick of a cycle lets that whole cycle complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| runReq | input | 1 | Pulse to start continuous cycling |
| stopReq | input | 1 | Pulse to halt at the end of the current cycle |
| stepReq | input | 1 | Rising edge runs one cycle while idle |
| incValue | input | DATA_W | Adder operand added to latch A |
| ph1Clr | output | 1 | Phase-one clear strobe |
| ph1Act | output | 1 | Phase-one activate strobe |
| ph3Clr | output | 1 | Phase-three clear strobe |
| ph3Act | output | 1 | Phase-three activate strobe |
| busy | output | 1 | A cycle is in progress |
| regD | output | DATA_W | Working register D |
| latchA | output | DATA_W | Adder input latch A |

## Verification
The delicate coincidence is a stop request that lands on the same tick on which the sequencer decides whether to start another cycle. That tick is the last tick of phase four. The bench raises `stopReq` exactly on that tick, and again one tick later on the first tick of the following cycle. The number of completed cycles is then judged from the final `regD` count and from `busy` falling. A second coincidence is a step edge that arrives mid-cycle. It must be absorbed without adding a cycle, and this too is judged by the final count.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

  // Index 0 is phase one, index 1 is phase three.
  typedef struct packed {
    logic [1:0] act;
    logic [1:0] clr;
    logic [1:0] load;
  } strobe_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import phase_seq_pkg::*;
#(
  parameter int PHASE_TICKS = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    runReq,
  input  logic    stopReq,
  input  logic    stepReq,
  output strobe_t strobes,
  output logic    busy
);

  localparam int TW = (PHASE_TICKS > 2) ? $clog2(PHASE_TICKS) : 2;
  localparam logic [TW-1:0] LAST_TICK = TW'(PHASE_TICKS - 1);
  localparam logic [TW-1:0] LAST_CLR  = TW'(PHASE_TICKS - 2);

  logic          active;
  logic          runMode;
  logic          stepPrev;
  logic [1:0]    phase;
  logic [TW-1:0] tick;

  logic stepEdge;
  logic lastTick;
  logic endCycle;
  logic runNext;
  logic startReq;

  assign stepEdge = stepReq && !stepPrev;
  assign lastTick = (tick == LAST_TICK);
  assign endCycle = active && lastTick && (phase == 2'd3);
  assign runNext  = stopReq ? 1'b0 : (runReq ? 1'b1 : runMode);
  assign startReq = (runReq && !stopReq) || stepEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepPrev <= 1'b0;
      runMode  <= 1'b0;
      active   <= 1'b0;
      phase    <= 2'd0;
      tick     <= '0;
    end else begin
      stepPrev <= stepReq;
      runMode  <= runNext;
      if (!active) begin
        if (startReq) begin
          active <= 1'b1;
          phase  <= 2'd0;
          tick   <= '0;
        end
      end else if (lastTick) begin
        tick  <= '0;
        phase <= phase + 2'd1;
        if (endCycle && !runNext) begin
          active <= 1'b0;
        end
      end else begin
        tick <= tick + TW'(1);
      end
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_strobe
    localparam logic [1:0] MY_PHASE = 2'(2 * i);
    logic inPhase;
    assign inPhase           = active && (phase == MY_PHASE);
    assign strobes.act[i]    = inPhase;
    assign strobes.clr[i]    = inPhase && (tick != '0) && (tick <= LAST_CLR);
    assign strobes.load[i]   = inPhase && lastTick;
  end

  assign busy = active;

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import phase_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] incValue,
  output logic [DATA_W-1:0] regD,
  output logic [DATA_W-1:0] latchA
);

  logic [DATA_W-1:0] sumOut;

  assign sumOut = latchA + incValue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regD   <= '0;
      latchA <= '0;
    end else begin
      if (strobes.load[0]) regD   <= sumOut;
      if (strobes.load[1]) latchA <= regD;
    end
  end

endmodule

// File: rtl/phase_clock_seq.sv
module phase_clock_seq
  import phase_seq_pkg::*;
#(
  parameter int PHASE_TICKS = 6,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runReq,
  input  logic              stopReq,
  input  logic              stepReq,
  input  logic [DATA_W-1:0] incValue,
  output logic              ph1Clr,
  output logic              ph1Act,
  output logic              ph3Clr,
  output logic              ph3Act,
  output logic              busy,
  output logic [DATA_W-1:0] regD,
  output logic [DATA_W-1:0] latchA
);

  strobe_t strobes;

  seq_ctrl #(.PHASE_TICKS(PHASE_TICKS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .runReq  (runReq),
    .stopReq (stopReq),
    .stepReq (stepReq),
    .strobes (strobes),
    .busy    (busy)
  );

  seq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .incValue (incValue),
    .regD     (regD),
    .latchA   (latchA)
  );

  assign ph1Act = strobes.act[0];
  assign ph1Clr = strobes.clr[0];
  assign ph3Act = strobes.act[1];
  assign ph3Clr = strobes.clr[1];

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int PHASE_TICKS = 6,
  parameter int DATA_W      = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] incValue,
  input logic              ph1Clr,
  input logic              ph1Act,
  input logic              ph3Clr,
  input logic              ph3Act,
  input logic              busy,
  input logic [DATA_W-1:0] regD,
  input logic [DATA_W-1:0] latchA
);

  localparam int CYC = 4 * PHASE_TICKS;
  localparam int CW  = $clog2(CYC);

  logic [CW-1:0] cycCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        cycCnt <= '0;
    else if (!busy)                   cycCnt <= '0;
    else if (cycCnt == CW'(CYC - 1))  cycCnt <= '0;
    else                              cycCnt <= cycCnt + CW'(1);
  end

  a_r3_clr1_nested: assert property (@(posedge clk) disable iff (!rstN)
    ph1Clr |-> ph1Act);
  a_r3_clr3_nested: assert property (@(posedge clk) disable iff (!rstN)
    ph3Clr |-> ph3Act);
  a_r3_clr1_late_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ph1Clr) |-> $past(ph1Act));
  a_r3_clr1_early_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ph1Act) |-> !$past(ph1Clr));
  a_r3_clr3_early_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ph3Act) |-> !$past(ph3Clr));
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(ph1Act && ph3Act));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(ph1Act || ph3Act || ph1Clr || ph3Clr));
  a_r4_load_d: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ph1Act) |-> regD == DATA_W'($past(latchA) + $past(incValue)));
  a_r4_load_a: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ph3Act) |-> latchA == $past(regD));
  a_r9_whole_cycle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(cycCnt) == CW'(CYC - 1));

endmodule

bind phase_clock_seq seq_checker #(
  .PHASE_TICKS(PHASE_TICKS),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .incValue (incValue),
  .ph1Clr   (ph1Clr),
  .ph1Act   (ph1Act),
  .ph3Clr   (ph3Clr),
  .ph3Act   (ph3Act),
  .busy     (busy),
  .regD     (regD),
  .latchA   (latchA)
);

// File: tb/tb_phase_clock_seq.sv
`timescale 1ns/1ps
module tb_phase_clock_seq;

  localparam int P   = 6;
  localparam int DW  = 8;
  localparam int CYC = 4 * P;
  localparam int NVEC = 4;
  // each row: increment, number of stepped cycles
  localparam int VEC [NVEC][2] = '{'{1, 1}, '{3, 4}, '{255, 2}, '{7, 5}};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          runReq = 1'b0;
  logic          stopReq = 1'b0;
  logic          stepReq = 1'b0;
  logic [DW-1:0] incValue = '0;
  logic          ph1Clr, ph1Act, ph3Clr, ph3Act, busy;
  logic [DW-1:0] regD, latchA;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;

  phase_clock_seq #(.PHASE_TICKS(P), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .runReq(runReq), .stopReq(stopReq),
    .stepReq(stepReq), .incValue(incValue), .ph1Clr(ph1Clr),
    .ph1Act(ph1Act), .ph3Clr(ph3Clr), .ph3Act(ph3Act), .busy(busy),
    .regD(regD), .latchA(latchA)
  );

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; runReq = 1'b0; stopReq = 1'b0; stepReq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // after return, tick 0 of the started cycle is visible
  task automatic stepPulse();
    @(negedge clk); stepReq = 1'b1;
    @(negedge clk); stepReq = 1'b0;
  endtask

  task automatic runThenStop(input int inc, input int stopAt, input int expCyc);
    doReset();
    incValue = DW'(inc);
    @(negedge clk); runReq = 1'b1;
    @(negedge clk); runReq = 1'b0;
    repeat (stopAt) @(negedge clk);
    chk("R8 busy while running", int'(busy), 1);
    stopReq = 1'b1;
    @(negedge clk); stopReq = 1'b0;
    repeat (2 * CYC) @(negedge clk);
    chk("R9 cycles before stop", int'(regD), (inc * expCyc) % 256);
    chk("R9 idle after stop", int'(busy), 0);
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    // R1 during and after reset
    repeat (2) @(negedge clk);
    chk("R1 strobes in reset", int'({ph1Act, ph1Clr, ph3Act, ph3Clr, busy}), 0);
    doReset();
    chk("R1 strobes after reset", int'({ph1Act, ph1Clr, ph3Act, ph3Clr, busy}), 0);
    chk("R1 regD after reset", int'(regD), 0);
    chk("R1 latchA after reset", int'(latchA), 0);

    // vector table: stepped counting (R4, R5)
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      incValue = DW'(VEC[v][0]);
      for (int k = 0; k < VEC[v][1]; k++) begin
        stepPulse();
        repeat (CYC + 2) @(negedge clk);
      end
      chk("R4 regD count", int'(regD), (VEC[v][0] * VEC[v][1]) % 256);
      chk("R4 latchA count", int'(latchA), (VEC[v][0] * VEC[v][1]) % 256);
      chk("R5 idle after steps", int'(busy), 0);
    end

    // strobe shape over one stepped cycle (R2, R3, R4, R5)
    doReset();
    incValue = 8'd3;
    stepPulse();
    for (int t = 0; t < CYC; t++) begin
      automatic int e1a = (t < P);
      automatic int e1c = (t >= 1 && t <= P - 2);
      automatic int e3a = (t >= 2 * P && t < 3 * P);
      automatic int e3c = (t >= 2 * P + 1 && t <= 3 * P - 2);
      chk("R2 R3 strobe pattern", int'({ph1Act, ph1Clr, ph3Act, ph3Clr}),
          (e1a << 3) | (e1c << 2) | (e3a << 1) | e3c);
      if (t == P + 1) begin
        chk("R4 regD after phase one", int'(regD), 3);
        chk("R4 latchA before phase three", int'(latchA), 0);
      end
      if (t == 3 * P + 1) chk("R4 latchA after phase three", int'(latchA), 3);
      chk("R5 busy in cycle", int'(busy), 1);
      @(negedge clk);
    end
    chk("R5 idle after one cycle", int'({busy, ph1Act, ph3Act}), 0);

    // R6 held step
    doReset();
    incValue = 8'd5;
    @(negedge clk); stepReq = 1'b1;
    repeat (3 * CYC) @(negedge clk);
    stepReq = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 held step one cycle", int'(regD), 5);
    chk("R6 idle", int'(busy), 0);

    // R7 step edge mid-cycle ignored
    doReset();
    incValue = 8'd9;
    stepPulse();
    repeat (10) @(negedge clk);
    stepPulse();
    repeat (CYC) @(negedge clk);
    chk("R7 mid-cycle step ignored", int'(regD), 9);
    chk("R7 idle", int'(busy), 0);

    // R8 / R9: stop on last tick, first tick, mid-cycle
    runThenStop(1, CYC - 1, 1);
    runThenStop(1, CYC, 2);
    runThenStop(2, 2 * CYC + 10, 3);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule